// File: doc/BRIEF.md
# Component Cache/Memory Register File

This block is the 32-bit register file that backs the cache/memory portion of a coherent-link port or device's component register space. Software reaches it through a single-cycle memory-mapped request port (valid, write flag, byte address, access size in bytes, write data). A read returns its data one cycle later, with a valid strobe.

A static component-type parameter decides how many capability structures exist. The block holds three groups of registers: a capability header array that lists those structures, the error-reporting (RAS) control registers, and the host-managed memory decoder registers. Every register has a write mask that is fixed at reset. A write keeps the unmasked bits of the stored word and replaces only the masked bits. Only aligned 4-byte accesses touch state. Any other access is ignored, and a read of that kind returns zero.

Address map (byte offsets):

| Offset | Contents |
|---|---|
| 0x000 | Top header |
| 0x004 onward | One capability entry per word |
| 0x040 | RAS group |
| 0x080 | Link region (all zero) |
| 0x0C0 | Extended-security region (all zero) |
| 0x0E0 | Snoop region (all zero) |
| 0x100 | Decoder capability word |
| 0x104 | Decoder global control |
| 0x110 + 0x20·d | Register set of decoder d |

Top module: `cm_regfile`

## Requirements
- R1: `rd_valid` is 1 in the cycle after a read request (`req_valid`=1 and `req_write`=0), and 0 in every other cycle, including the cycles spent in reset.
- R2: An access with `req_size`=8 has no effect on state. When it is a read, it returns zero.
- R3: An access is ignored when `req_size` is not 4 or 8, or when `req_addr[1:0]` is not 0. A write of this kind changes no state, and a read of this kind returns zero.
- R4: An aligned 4-byte write stores `(wdata & mask) | (old & ~mask)`, so bits outside the register's write mask keep their value.
- R5: The top header at 0x000 reads `{count[31:24], 4'h1[23:20], 4'h1[19:16], 16'h0001}`. The count depends on `COMP_TYPE`:
  - 2 for 0 (downstream port) and 1 (generic device);
  - 3 for 2 (upstream port), 3 (type-3 device) and 4 (logical device);
  - 5 for 5 (root port).
- R6: Capability entry k sits at 0x004+4k and reads `{pointer[31:20], version[19:16], id[15:0]}`. The entries, in this order, are:
  - RAS: id 2, version 2, pointer 0x040;
  - Link: id 4, version 2, pointer 0x080;
  - decoder block: id 5, version 1, pointer 0x100;
  - extended security: id 6, version 1, pointer 0x0C0;
  - snoop: id 8, version 1, pointer 0x0E0.

  Entries at or beyond the count read zero.
- R7: The RAS registers are:
  - uncorrectable status (0x040): reads 0;
  - uncorrectable mask (0x044): resets to 0x1CFFF, write mask 0x1CFFF;
  - uncorrectable severity (0x048): resets to 0x1CFFF, write mask 0x1CFFF;
  - correctable status (0x04C): reads 0;
  - correctable mask (0x050): resets to 0x7F, write mask 0x7F;
  - capability control (0x054): reads 0.
- R8: When the decoder block exists (count ≥ 3), the decoder capability word at 0x100 is read-only. Its fields are:
  - [3:0]: encoded decoder count, equal to log2 of `NUM_DEC`;
  - [7:4]: target count 1;
  - bit 8: 256-byte interleave, set;
  - bit 9: 4K interleave, set;
  - bit 10: poison-on-error, clear.

  Global control at 0x104 resets to 0 and has write mask 0x3.
- R9: Decoder d's register set starts at 0x110+0x20·d and holds five registers, all resetting to 0:
  - base-low (+0x0): write mask 0xF0000000;
  - base-high (+0x4): write mask 0xFFFFFFFF;
  - size-low (+0x8): write mask 0xF0000000;
  - size-high (+0xC): write mask 0xFFFFFFFF;
  - control (+0x10): write mask 0x13FF.
- R10: Every other offset resets to zero, has a zero write mask, and keeps reading zero after writes. This includes the whole decoder region when the count is below 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the region |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a rejected access aimed at a register that already holds a non-reset value. For an 8-byte or misaligned write to prove anything, there must be state it could visibly corrupt. The bench therefore first loads a decoder high word with a distinctive pattern. It then issues the rejected write to that same word and reads the word back with a legal access. A second instance, built as a downstream port, shows that the decoder region and the third capability entry do not exist for that type even after full-mask writes.

// File: rtl/cm_regfile.sv
module cm_regfile #(
  parameter int COMP_TYPE = 5,
  parameter int ADDR_W    = 10,
  parameter int NUM_DEC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  localparam int NWORDS   = 2 ** (ADDR_W - 2);
  localparam int CAP_N    = (COMP_TYPE <= 1) ? 2 : (COMP_TYPE <= 4) ? 3 : 5;
  localparam bit HAS_HDM  = CAP_N >= 3;
  localparam int RAS_OFF  = 'h040;
  localparam int LINK_OFF = 'h080;
  localparam int SEC_OFF  = 'h0C0;
  localparam int SNP_OFF  = 'h0E0;
  localparam int HDM_OFF  = 'h100;
  localparam int DEC_OFF  = HDM_OFF + 'h10;
  localparam int DEC_STEP = 'h20;
  localparam logic [31:0] HDR0 = {8'(CAP_N), 4'd1, 4'd1, 16'd1};
  localparam logic [31:0] HDM_CAP =
      {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, 4'($clog2(NUM_DEC))};

  function automatic logic [31:0] cap_entry(int k);
    case (k)
      0: return {12'(RAS_OFF),  4'd2, 16'd2};
      1: return {12'(LINK_OFF), 4'd2, 16'd4};
      2: return {12'(HDM_OFF),  4'd1, 16'd5};
      3: return {12'(SEC_OFF),  4'd1, 16'd6};
      4: return {12'(SNP_OFF),  4'd1, 16'd8};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] reset_of(int b);
    logic [31:0] v;
    v = 32'd0;
    if (b == 0) v = HDR0;
    for (int k = 0; k < CAP_N; k++)
      if (b == 4 + 4 * k) v = cap_entry(k);
    if (b == RAS_OFF + 4 || b == RAS_OFF + 8) v = 32'h1CFFF;
    if (b == RAS_OFF + 'h10) v = 32'h7F;
    if (HAS_HDM && b == HDM_OFF) v = HDM_CAP;
    return v;
  endfunction

  function automatic logic [31:0] mask_of(int b);
    logic [31:0] m;
    m = 32'd0;
    if (b == RAS_OFF + 4 || b == RAS_OFF + 8) m = 32'h1CFFF;
    if (b == RAS_OFF + 'h10) m = 32'h7F;
    if (HAS_HDM) begin
      if (b == HDM_OFF + 4) m = 32'h3;
      for (int d = 0; d < NUM_DEC; d++) begin
        if (b == DEC_OFF + DEC_STEP * d || b == DEC_OFF + DEC_STEP * d + 8)
          m = 32'hF000_0000;
        if (b == DEC_OFF + DEC_STEP * d + 4 || b == DEC_OFF + DEC_STEP * d + 'hC)
          m = 32'hFFFF_FFFF;
        if (b == DEC_OFF + DEC_STEP * d + 'h10) m = 32'h13FF;
      end
    end
    return m;
  endfunction

  logic [31:0] wmask [NWORDS];
  logic [31:0] rstv  [NWORDS];
  logic [31:0] regs  [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign wmask[g] = mask_of(g * 4);
    assign rstv[g]  = reset_of(g * 4);
  end

  logic [ADDR_W-3:0] widx;
  logic              acc_ok, rd_req;
  assign widx   = req_addr[ADDR_W-1:2];
  assign acc_ok = req_valid && req_size == 4'd4 && req_addr[1:0] == 2'b00;
  assign rd_req = req_valid && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= rstv[i];
      rd_valid <= 1'b0;
      rd_data  <= 32'd0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= acc_ok ? regs[widx] : 32'd0;
      if (acc_ok && req_write)
        regs[widx] <= (req_wdata & wmask[widx]) | (regs[widx] & ~wmask[widx]);
    end
  end
endmodule

// File: rtl/cm_regfile_chk.sv
module cm_regfile_chk #(
  parameter int          ADDR_W = 10,
  parameter logic [31:0] HDR0   = 32'd0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic              rd_valid,
  input logic [31:0]       rd_data
);
  // R1
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  // R1
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  // R2
  wide_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd8) |=> rd_data == 32'd0);
  // R3
  misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[1:0] != 2'b00) |=> rd_data == 32'd0);
  // R5
  top_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd4 && req_addr == '0) |=> rd_data == HDR0);
endmodule

bind cm_regfile cm_regfile_chk #(.ADDR_W(ADDR_W), .HDR0(HDR0)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/cm_regfile_test.sv
`timescale 1ns/1ps
module cm_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [3:0]  req_size = 4'd4;
  logic [31:0] req_wdata = '0;
  logic        rv_a, rv_b;
  logic [31:0] rd_a, rd_b;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cm_regfile #(.COMP_TYPE(5)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rv_a), .rd_data(rd_a));

  cm_regfile #(.COMP_TYPE(0)) uut_dp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rv_b), .rd_data(rd_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, logic [3:0] sz = 4'd4);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(string req, bit dp, logic [9:0] a, logic [31:0] exp,
                    logic [3:0] sz = 4'd4);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, {31'd0, dp ? rv_b : rv_a}, 32'd1);
    chk(req, dp ? rd_b : rd_a, exp);
    @(negedge clk);
    chk({req, " strobe drop"}, {31'd0, dp ? rv_b : rv_a}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid low in reset", {31'd0, rv_a}, 32'd0);
    chk("R1 data zero in reset", rd_a, 32'd0);
  endtask

  task automatic t_headers;
    rd("R5 root header", 0, 10'h000, 32'h0511_0001);
    rd("R5 downstream header", 1, 10'h000, 32'h0211_0001);
    rd("R6 RAS entry", 0, 10'h004, 32'h0402_0002);
    rd("R6 link entry", 0, 10'h008, 32'h0802_0004);
    rd("R6 decoder entry", 0, 10'h00C, 32'h1001_0005);
    rd("R6 extsec entry", 0, 10'h010, 32'h0C01_0006);
    rd("R6 snoop entry", 0, 10'h014, 32'h0E01_0008);
    rd("R6 downstream has no decoder entry", 1, 10'h00C, 32'h0);
    wr(10'h000, 32'h0);
    rd("R10 header ignores write", 0, 10'h000, 32'h0511_0001);
  endtask

  task automatic t_ras;
    rd("R7 unc mask reset", 0, 10'h044, 32'h1CFFF);
    rd("R7 unc severity reset", 0, 10'h048, 32'h1CFFF);
    rd("R7 cor mask reset", 0, 10'h050, 32'h7F);
    wr(10'h044, 32'h0);
    rd("R4 unc mask cleared", 0, 10'h044, 32'h0);
    wr(10'h044, 32'h12345);
    rd("R4 unc mask partial", 0, 10'h044, 32'h10345);
    wr(10'h048, 32'hFFFF_FFFF);
    rd("R7 unc severity masked", 0, 10'h048, 32'h1CFFF);
    wr(10'h050, 32'hFFFF_FF00);
    rd("R4 cor mask low bits", 0, 10'h050, 32'h0);
    wr(10'h040, 32'hFFFF_FFFF);
    rd("R7 unc status stays zero", 0, 10'h040, 32'h0);
    wr(10'h04C, 32'hFFFF_FFFF);
    rd("R7 cor status stays zero", 0, 10'h04C, 32'h0);
  endtask

  task automatic t_hdm;
    rd("R8 decoder capability", 0, 10'h100, 32'h0000_0310);
    wr(10'h100, 32'hFFFF_FFFF);
    rd("R8 capability read-only", 0, 10'h100, 32'h0000_0310);
    rd("R8 global control reset", 0, 10'h104, 32'h0);
    wr(10'h104, 32'hFFFF_FFFF);
    rd("R8 global control mask", 0, 10'h104, 32'h3);
    wr(10'h110, 32'hFFFF_FFFF);
    rd("R9 base low mask", 0, 10'h110, 32'hF000_0000);
    wr(10'h114, 32'hDEAD_BEEF);
    rd("R9 base high", 0, 10'h114, 32'hDEAD_BEEF);
    wr(10'h118, 32'h5A5A_5A5A);
    rd("R9 size low mask", 0, 10'h118, 32'h5000_0000);
    wr(10'h11C, 32'h0123_4567);
    rd("R9 size high", 0, 10'h11C, 32'h0123_4567);
    wr(10'h120, 32'hFFFF_FFFF);
    rd("R9 control mask", 0, 10'h120, 32'h13FF);
    wr(10'h130, 32'hFFFF_FFFF);
    rd("R10 beyond last decoder", 0, 10'h130, 32'h0);
    rd("R10 downstream no decoder cap", 1, 10'h100, 32'h0);
    rd("R10 downstream base high ignored", 1, 10'h114, 32'h0);
  endtask

  task automatic t_rejects;
    wr(10'h114, 32'h0, 4'd8);
    rd("R2 wide write no change", 0, 10'h114, 32'hDEAD_BEEF);
    rd("R2 wide read zero", 0, 10'h114, 32'h0, 4'd8);
    wr(10'h114, 32'h0, 4'd2);
    rd("R3 short write ignored", 0, 10'h114, 32'hDEAD_BEEF);
    wr(10'h115, 32'h0);
    rd("R3 misaligned write ignored", 0, 10'h114, 32'hDEAD_BEEF);
    rd("R3 misaligned read zero", 0, 10'h116, 32'h0);
    rd("R3 short read zero", 0, 10'h114, 32'h0, 4'd1);
    wr(10'h3FC, 32'hFFFF_FFFF);
    rd("R10 unmapped reads zero", 0, 10'h3FC, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_headers();
        t_ras();
        t_hdm();
        t_rejects();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule